// File: doc/BRIEF.md
# Twisted-Ring Addressed Serial Pattern Generator

This block emits a serial bit stream that repeats every six clocks. A three-stage twisted-ring counter is built as a shift register. On every clock it shifts its state one place toward the top bit, and the complement of the top bit enters the bottom bit. The counter state drives the select lines of an eight-way data selector. The selector picks one bit of a programmable eight-bit pattern word and presents it on the serial output.

The counter walks a non-binary path through the select space. For that reason only six of the eight pattern bits ever reach the output, and they are taken in a fixed scrambled order. Firmware or a neighbouring block loads the pattern word to choose the repeating six-bit waveform. The counter state is also brought out, so that other logic can align to the phase of the sequence.

If an upset puts the counter in one of the two states outside the ring, that state is recognised and the counter is cleared on the next clock, so it cannot stay stuck in a parasitic loop.

Top module: `jsg_top`

## Requirements
- R1: A clock edge with `rst` high sets `phase` to 3'b000. While `phase` is 3'b000, `serial_out` equals `pattern[0]`.
- R2: With `rst` low, each clock edge moves `phase` one step along 000, 001, 011, 111, 110, 100 and back to 000. The new bit 0 is the inverse of the old bit 2, and bits 2:1 take the old bits 1:0.
- R3: The sequence repeats with a period of exactly 6 clocks.
- R4: `serial_out` equals `pattern[phase]`, read as an unsigned index, in the same cycle, with no register between them. A change to `pattern` is therefore visible before the next clock edge.
- R5: Pattern bits 2 and 5 never affect `serial_out`. The bits that are used appear in the order 0, 1, 3, 7, 6, 4.
- R6: `phase` never rests in 3'b010 or 3'b101. If either state occurs, the next clock edge clears `phase` to 3'b000.
- R7: With `pattern` = 8'h8B (bits 0, 1, 3 and 7 set; bits 4 and 6 clear), the output repeats 1,1,1,1,0,0 starting from phase 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pattern | input | 8 | Programmable source bits for the selector |
| serial_out | output | 1 | Selected pattern bit |
| phase | output | 3 | Current twisted-ring counter state |

## Verification
On every cycle the assertions check the counter's step rule, that the counter is cleared after reset and after a state outside the ring, and that the output matches the indexed pattern bit. The two states outside the ring cannot be reached through the ports, so only the assertion shows that recovery from them works. The bench's scenarios are what show the six-step visiting order, the six-clock period, the same-cycle response to a pattern rewrite, and the insensitivity to bits 2 and 5, each measured against a behavioural model.

// File: rtl/jsg_pkg.sv
package jsg_pkg;
   function automatic int ring_length(input int stages);
      return 2 * stages;
   endfunction

   function automatic int pattern_width(input int stages);
      return 1 << stages;
   endfunction
endpackage

// File: rtl/jsg_ring.sv
module jsg_ring #(
   parameter int STAGES  = 3,
   parameter bit RECOVER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [STAGES-1:0] q
);
   localparam int TOP = STAGES - 1;

   logic [STAGES-1:0] shift_d;
   logic [STAGES-1:0] next_q;
   logic              in_ring;
   int                edges;

   generate
      if (STAGES < 2) begin : g_bad
         $error("jsg_ring: STAGES must be at least 2");
      end
   endgenerate

   // A ring state has at most one boundary between adjacent bits.
   always_comb begin
      edges = 0;
      for (int i = 0; i < TOP; i++)
         if (q[i] != q[i+1]) edges++;
      in_ring = (edges <= 1);
   end

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_low
            assign shift_d[s] = ~q[TOP];
         end else begin : g_up
            assign shift_d[s] = q[s-1];
         end
      end
      if (RECOVER) begin : g_fix
         assign next_q = in_ring ? shift_d : '0;
      end else begin : g_nofix
         assign next_q = shift_d;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= next_q;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
   AST_LOW_BIT_INVERTS: assert property (@(posedge clk) disable iff (rst)
      in_ring |=> (q[0] == ~$past(q[TOP]))); // R2
   AST_UPPER_SHIFT: assert property (@(posedge clk) disable iff (rst)
      in_ring |=> (q[TOP:1] == $past(q[TOP-1:0]))); // R2
   AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (rst)
      in_ring |=> ($countones(q ^ $past(q)) == 1)); // R3
   AST_OFF_RING_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (!in_ring && RECOVER) |=> (q == '0)); // R6
endmodule

// File: rtl/jsg_select.sv
module jsg_select #(
   parameter int SEL_W = 3,
   parameter int DAT_W = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [DAT_W-1:0] data,
   output logic             bit_out
);
   logic [DAT_W-1:0] hit;

   generate
      if (DAT_W != (1 << SEL_W)) begin : g_bad
         $error("jsg_select: DAT_W must equal 2**SEL_W");
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < DAT_W; k++) begin : g_leg
         assign hit[k] = data[k] & (sel == SEL_W'(k));
      end
   endgenerate

   assign bit_out = |hit;

   always_comb begin
      AST_ONE_LEG: assert ($onehot0(hit)); // R4
   end
endmodule

// File: rtl/jsg_top.sv
module jsg_top #(
   parameter int STAGES = 3
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic [jsg_pkg::pattern_width(STAGES)-1:0] pattern,
   output logic                                 serial_out,
   output logic [STAGES-1:0]                    phase
);
   localparam int PAT_W = jsg_pkg::pattern_width(STAGES);

   jsg_ring #(.STAGES(STAGES), .RECOVER(1'b1)) u_ring (
      .clk (clk),
      .rst (rst),
      .q   (phase)
   );

   jsg_select #(.SEL_W(STAGES), .DAT_W(PAT_W)) u_sel (
      .sel     (phase),
      .data    (pattern),
      .bit_out (serial_out)
   );

   AST_OUT_TRACKS: assert property (@(posedge clk) disable iff (rst)
      serial_out == pattern[phase]); // R4
   AST_IDLE_BIT0: assert property (@(posedge clk) disable iff (rst)
      (phase == '0) |-> (serial_out == pattern[0])); // R1
endmodule

// File: tb/jsg_top_test.sv
module jsg_top_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] pattern = 8'h00;
   logic       serial_out;
   logic [2:0] phase;

   int checks = 0;
   int fails  = 0;
   int idx    = 0;
   int order[$] = '{0, 1, 3, 7, 6, 4};

   always #10 clk = ~clk;

   jsg_top uut (.clk(clk), .rst(rst), .pattern(pattern),
                .serial_out(serial_out), .phase(phase));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock; model advances, then outputs compared at the falling edge
   task automatic step();
      @(posedge clk);
      if (rst) idx = 0; else idx = (idx + 1) % 6;
      @(negedge clk);
      check("R2 phase", phase, order[idx]);
      check("R4 out", serial_out, pattern[order[idx]]);
      check("R6 ring", int'(phase == 3'b010 || phase == 3'b101), 0);
   endtask

   initial begin
      #3000000;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      pattern = 8'hA5;
      @(posedge clk); @(negedge clk);
      check("R1 reset phase", phase, 0);
      check("R1 reset out", serial_out, pattern[0]);
      step();
      rst = 1'b0;
      for (int c = 0; c < 14; c++) step();

      // R3: period of six, with a marker pattern
      pattern = 8'h01;
      while (phase != 3'b000) step();
      for (int c = 0; c < 6; c++) begin
         step();
         check("R3 period", serial_out, (c == 5) ? 1 : 0);
      end

      // R7: known waveform
      pattern = 8'h8B;
      while (phase != 3'b000) step();
      for (int c = 0; c < 12; c++) begin
         check("R7 wave", serial_out, ((c % 6) < 4) ? 1 : 0);
         step();
      end

      // R5: bits 2 and 5 have no effect across full periods
      for (int c = 0; c < 12; c++) begin
         logic prev;
         prev = serial_out;
         pattern[2] = ~pattern[2];
         pattern[5] = ~pattern[5];
         #1;
         check("R5 unused", serial_out, prev);
         step();
      end

      // R4: same-cycle response to a pattern change
      for (int c = 0; c < 6; c++) begin
         pattern = 8'h00; #1;
         check("R4 clear", serial_out, 0);
         pattern = 8'hFF; #1;
         check("R4 set", serial_out, 1);
         step();
      end

      // R1: mid-sequence reset
      while (phase != 3'b111) step();
      rst = 1'b1;
      step();
      check("R1 mid reset", phase, 0);
      rst = 1'b0;
      for (int c = 0; c < 8; c++) step();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule